// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block holds the working accumulator of a small stored-program processor, together with the network of adders and logic that feeds it and a one-bit extension flag. The sequencer drives it with decoded, one-hot strobes. Each strobe picks one fixed source for the next accumulator value: a bitwise or arithmetic combination with the data register operand, a straight copy of that operand, an 8-bit character taken into the low byte, or an operation on the accumulator itself. The accumulator and the flag change on the rising clock edge that follows a strobe.

The extension flag takes the carry out of the adder. It is also the extra bit that the accumulator rotates through in both directions. Two strobes act only on the flag: one clears it and one inverts it. The accumulator value drives the processor bus port. The block also exports a sign flag and an all-zero flag, so that outside logic can decide whether to skip the next instruction.

Any combination of more than one strobe is illegal. It changes nothing: the accumulator and the flag both keep their values.

Top module: `acc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator is set to 0 and the extension flag to 0.
- R2: `op_and` sets the accumulator to the bitwise AND of itself and `dr_in`. The extension flag keeps its value.
- R3: `op_add` adds `dr_in` to the accumulator, modulo 2^16. The carry out of bit 15 goes into the extension flag.
- R4: `op_load` copies `dr_in` into the accumulator. The extension flag keeps its value.
- R5: `op_char` writes `char_in` into accumulator bits 7..0. Bits 15..8 and the extension flag keep their values.
- R6: `op_inv` inverts every accumulator bit. The extension flag keeps its value.
- R7: `op_rotr` shifts the accumulator one place toward bit 0. The old flag enters bit 15, and the flag takes the old bit 0.
- R8: `op_rotl` shifts the accumulator one place toward bit 15. The old flag enters bit 0, and the flag takes the old bit 15.
- R9: `op_incr` adds one to the accumulator, so 16'hFFFF wraps to 0. The extension flag keeps its value.
- R10: `op_zero` sets the accumulator to 0. The extension flag keeps its value.
- R11: `op_eclr` sets the extension flag to 0 and `op_einv` inverts it. Neither changes the accumulator.
- R12: In a cycle with no strobe asserted, the accumulator and the extension flag keep their values.
- R13: In a cycle with two or more strobes asserted, the accumulator and the extension flag keep their values.
- R14: `neg_o` equals accumulator bit 15. `zero_o` is high exactly when all 16 accumulator bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dr_in | input | 16 | Data register operand |
| char_in | input | 8 | Input character |
| op_and | input | 1 | Strobe: AND with operand |
| op_add | input | 1 | Strobe: add operand, carry into flag |
| op_load | input | 1 | Strobe: copy operand |
| op_char | input | 1 | Strobe: take character into low byte |
| op_inv | input | 1 | Strobe: complement accumulator |
| op_rotr | input | 1 | Strobe: rotate right through flag |
| op_rotl | input | 1 | Strobe: rotate left through flag |
| op_incr | input | 1 | Strobe: increment accumulator |
| op_zero | input | 1 | Strobe: clear accumulator |
| op_eclr | input | 1 | Strobe: clear extension flag |
| op_einv | input | 1 | Strobe: complement extension flag |
| acc_o | output | 16 | Accumulator value to the bus |
| ext_o | output | 1 | Extension flag |
| neg_o | output | 1 | Accumulator sign bit |
| zero_o | output | 1 | Accumulator is all zero |

## Verification
The bench builds the block with its default widths: a 16-bit accumulator and an 8-bit character. With these widths the wrap from 16'hFFFF is within reach of a single strobe, and so is the carry that 16'hFFFF plus one leaves in the flag. A character written into a full-width value shows whether the upper byte is kept. Rotates with the flag set and clear show which bit enters at bit 15 and at bit 0, and which bit leaves into the flag.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Number of decoded strobes entering the unit. This order is the
    // vector order used at the top level.
    localparam int NUM_STROBES = 11;

    localparam int S_AND  = 0;
    localparam int S_ADD  = 1;
    localparam int S_LOAD = 2;
    localparam int S_CHAR = 3;
    localparam int S_INV  = 4;
    localparam int S_ROTR = 5;
    localparam int S_ROTL = 6;
    localparam int S_INCR = 7;
    localparam int S_ZERO = 8;
    localparam int S_ECLR = 9;
    localparam int S_EINV = 10;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_AND  = 4'd1,
        OP_ADD  = 4'd2,
        OP_LOAD = 4'd3,
        OP_CHAR = 4'd4,
        OP_INV  = 4'd5,
        OP_ROTR = 4'd6,
        OP_ROTL = 4'd7,
        OP_INCR = 4'd8,
        OP_ZERO = 4'd9,
        OP_ECLR = 4'd10,
        OP_EINV = 4'd11
    } acc_op_e;

    typedef struct packed {
        logic    valid;
        acc_op_e op;
    } acc_ctl_t;

    function automatic acc_op_e strobe_to_op(input int idx);
        acc_op_e r;
        case (idx)
            S_AND:   r = OP_AND;
            S_ADD:   r = OP_ADD;
            S_LOAD:  r = OP_LOAD;
            S_CHAR:  r = OP_CHAR;
            S_INV:   r = OP_INV;
            S_ROTR:  r = OP_ROTR;
            S_ROTL:  r = OP_ROTL;
            S_INCR:  r = OP_INCR;
            S_ZERO:  r = OP_ZERO;
            S_ECLR:  r = OP_ECLR;
            S_EINV:  r = OP_EINV;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    // Operations that use the load path of the accumulator. Increment and
    // clear have their own controls.
    function automatic logic uses_load_path(input acc_op_e op);
        return (op == OP_AND) || (op == OP_ADD) || (op == OP_LOAD) ||
               (op == OP_CHAR) || (op == OP_INV) || (op == OP_ROTR) ||
               (op == OP_ROTL);
    endfunction

endpackage

// File: rtl/acc_strobe_decode.sv
module acc_strobe_decode
    import acc_pkg::*;
(
    input  logic [NUM_STROBES-1:0] strb,
    output acc_ctl_t               ctl
);

    logic single;

    assign single = $onehot(strb);

    always_comb begin
        ctl.valid = single;
        ctl.op    = OP_NONE;
        for (int i = 0; i < NUM_STROBES; i++) begin
            if (single && strb[i]) begin
                ctl.op = strobe_to_op(i);
            end
        end
    end

endmodule

// File: rtl/acc_logic_net.sv
module acc_logic_net
    import acc_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 8
) (
    input  acc_op_e        op,
    input  logic [W-1:0]   ac,
    input  logic           e,
    input  logic [W-1:0]   dr,
    input  logic [CW-1:0]  ch,
    output logic [W-1:0]   ac_nxt,
    output logic           e_nxt,
    output logic           ld_en,
    output logic           inc_en,
    output logic           clr_en
);

    logic [W:0]   sum;
    logic [W-1:0] char_word;
    logic [W-1:0] ld_val;
    logic         ld_e;

    assign sum = {1'b0, ac} + {1'b0, dr};

    generate
        if (CW < W) begin : g_char_low
            assign char_word = {ac[W-1:CW], ch};
        end else begin : g_char_full
            assign char_word = ch[W-1:0];
        end
    endgenerate

    // The load path picks one value from the adder and logic network.
    always_comb begin
        ld_val = ac;
        ld_e   = e;
        case (op)
            OP_AND:  ld_val = ac & dr;
            OP_ADD:  {ld_e, ld_val} = sum;
            OP_LOAD: ld_val = dr;
            OP_CHAR: ld_val = char_word;
            OP_INV:  ld_val = ~ac;
            OP_ROTR: begin
                ld_val = {e, ac[W-1:1]};
                ld_e   = ac[0];
            end
            OP_ROTL: begin
                ld_val = {ac[W-2:0], e};
                ld_e   = ac[W-1];
            end
            default: ;
        endcase
    end

    assign ld_en  = uses_load_path(op);
    assign inc_en = (op == OP_INCR);
    assign clr_en = (op == OP_ZERO);

    always_comb begin
        if (clr_en) begin
            ac_nxt = '0;
        end else if (inc_en) begin
            ac_nxt = ac + W'(1);
        end else if (ld_en) begin
            ac_nxt = ld_val;
        end else begin
            ac_nxt = ac;
        end

        if (op == OP_ECLR) begin
            e_nxt = 1'b0;
        end else if (op == OP_EINV) begin
            e_nxt = ~e;
        end else if (ld_en) begin
            e_nxt = ld_e;
        end else begin
            e_nxt = e;
        end
    end

endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] ac,
    output logic         neg,
    output logic         zero
);

    logic [W-1:0] any_set;

    generate
        for (genvar i = 0; i < W; i++) begin : g_or
            if (i == 0) begin : g_first
                assign any_set[i] = ac[i];
            end else begin : g_rest
                assign any_set[i] = any_set[i-1] | ac[i];
            end
        end
    endgenerate

    assign neg  = ac[W-1];
    assign zero = ~any_set[W-1];

endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  dr_in,
    input  logic [CW-1:0] char_in,
    input  logic          op_and,
    input  logic          op_add,
    input  logic          op_load,
    input  logic          op_char,
    input  logic          op_inv,
    input  logic          op_rotr,
    input  logic          op_rotl,
    input  logic          op_incr,
    input  logic          op_zero,
    input  logic          op_eclr,
    input  logic          op_einv,
    output logic [W-1:0]  acc_o,
    output logic          ext_o,
    output logic          neg_o,
    output logic          zero_o
);

    logic [NUM_STROBES-1:0] strb;
    acc_ctl_t               ctl;
    logic [W-1:0]           ac_q;
    logic                   e_q;
    logic [W-1:0]           ac_nxt;
    logic                   e_nxt;
    logic                   ld_en;
    logic                   inc_en;
    logic                   clr_en;

    always_comb begin
        strb         = '0;
        strb[S_AND]  = op_and;
        strb[S_ADD]  = op_add;
        strb[S_LOAD] = op_load;
        strb[S_CHAR] = op_char;
        strb[S_INV]  = op_inv;
        strb[S_ROTR] = op_rotr;
        strb[S_ROTL] = op_rotl;
        strb[S_INCR] = op_incr;
        strb[S_ZERO] = op_zero;
        strb[S_ECLR] = op_eclr;
        strb[S_EINV] = op_einv;
    end

    acc_strobe_decode u_dec (
        .strb (strb),
        .ctl  (ctl)
    );

    acc_logic_net #(.W(W), .CW(CW)) u_net (
        .op     (ctl.op),
        .ac     (ac_q),
        .e      (e_q),
        .dr     (dr_in),
        .ch     (char_in),
        .ac_nxt (ac_nxt),
        .e_nxt  (e_nxt),
        .ld_en  (ld_en),
        .inc_en (inc_en),
        .clr_en (clr_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else if (ctl.valid) begin
            ac_q <= ac_nxt;
            e_q  <= e_nxt;
        end
    end

    acc_flags #(.W(W)) u_flags (
        .ac   (ac_q),
        .neg  (neg_o),
        .zero (zero_o)
    );

    assign acc_o = ac_q;
    assign ext_o = e_q;

    // R13: with more than one strobe, none of the three controls may be enabled.
    a_r13_no_ctrl_on_multi: assert property (@(posedge clk) disable iff (rst)
        ($countones(strb) > 1) |-> !(ld_en || inc_en || clr_en));

    a_r13_multi_hold: assert property (@(posedge clk) disable iff (rst)
        ($countones(strb) > 1) |=> (ac_q == $past(ac_q) && e_q == $past(e_q)));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (strb == '0) |=> (ac_q == $past(ac_q) && e_q == $past(e_q)));

    a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
        (op_add && $onehot(strb)) |=>
        ({e_q, ac_q} == ({1'b0, $past(ac_q)} + {1'b0, $past(dr_in)})));

    a_r7_rotate_right: assert property (@(posedge clk) disable iff (rst)
        (op_rotr && $onehot(strb)) |=>
        (ac_q == {$past(e_q), $past(ac_q[W-1:1])} && e_q == $past(ac_q[0])));

    a_r8_rotate_left: assert property (@(posedge clk) disable iff (rst)
        (op_rotl && $onehot(strb)) |=>
        (ac_q == {$past(ac_q[W-2:0]), $past(e_q)} && e_q == $past(ac_q[W-1])));

    a_r11_eclr_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (op_eclr && $onehot(strb)) |=> (!e_q && $stable(ac_q)));

endmodule

// File: tb/acc_unit_test.sv
module acc_unit_test;

    localparam int W  = 16;
    localparam int CW = 8;

    // Bench-side strobe order
    localparam int B_AND  = 0;
    localparam int B_ADD  = 1;
    localparam int B_LOAD = 2;
    localparam int B_CHAR = 3;
    localparam int B_INV  = 4;
    localparam int B_ROTR = 5;
    localparam int B_ROTL = 6;
    localparam int B_INCR = 7;
    localparam int B_ZERO = 8;
    localparam int B_ECLR = 9;
    localparam int B_EINV = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  dr_in = '0;
    logic [CW-1:0] char_in = '0;
    logic [10:0]   sv = '0;
    logic [W-1:0]  acc_o;
    logic          ext_o, neg_o, zero_o;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_ac;
    logic         m_e;

    always #10 clk = ~clk;

    acc_unit #(.W(W), .CW(CW)) uut (
        .clk     (clk),
        .rst     (rst),
        .dr_in   (dr_in),
        .char_in (char_in),
        .op_and  (sv[B_AND]),
        .op_add  (sv[B_ADD]),
        .op_load (sv[B_LOAD]),
        .op_char (sv[B_CHAR]),
        .op_inv  (sv[B_INV]),
        .op_rotr (sv[B_ROTR]),
        .op_rotl (sv[B_ROTL]),
        .op_incr (sv[B_INCR]),
        .op_zero (sv[B_ZERO]),
        .op_eclr (sv[B_ECLR]),
        .op_einv (sv[B_EINV]),
        .acc_o   (acc_o),
        .ext_o   (ext_o),
        .neg_o   (neg_o),
        .zero_o  (zero_o)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " acc"}, acc_o, m_ac);
        check({req, " ext"}, W'(ext_o), W'(m_e));
    endtask

    // Drive strobes for one cycle; outputs are sampled at the next falling edge.
    task automatic pulse(input logic [10:0] v, input logic [W-1:0] d, input logic [CW-1:0] c);
        @(negedge clk);
        sv = v; dr_in = d; char_in = c;
        @(negedge clk);
        sv = '0;
    endtask

    task automatic set_acc(input logic [W-1:0] v);
        pulse(11'(1) << B_LOAD, v, '0);
        m_ac = v;
    endtask

    task automatic set_e(input logic v);
        pulse(11'(1) << B_ECLR, '0, '0);
        m_e = 1'b0;
        if (v) begin
            pulse(11'(1) << B_EINV, '0, '0);
            m_e = 1'b1;
        end
    endtask

    task automatic t_reset;
        m_ac = '0; m_e = 1'b0;
        check_state("R1");
        check("R14 zero at reset", W'(zero_o), W'(1));
        check("R14 neg at reset", W'(neg_o), W'(0));
    endtask

    task automatic t_load;
        set_e(1'b1);
        set_acc(16'hF0F0);
        check_state("R4");
        check("R14 neg", W'(neg_o), W'(1));
        check("R14 zero", W'(zero_o), W'(0));
    endtask

    task automatic t_and;
        set_acc(16'hF0F0);
        pulse(11'(1) << B_AND, 16'h3C3C, '0);
        m_ac = 16'h3030;
        check_state("R2");
    endtask

    task automatic t_add;
        set_e(1'b1);
        set_acc(16'h1234);
        pulse(11'(1) << B_ADD, 16'h0FFF, '0);
        m_ac = 16'h2233; m_e = 1'b0;
        check_state("R3 no carry");
        set_acc(16'hFFFF);
        pulse(11'(1) << B_ADD, 16'h0001, '0);
        m_ac = 16'h0000; m_e = 1'b1;
        check_state("R3 carry out");
        check("R14 zero after wrap", W'(zero_o), W'(1));
    endtask

    task automatic t_char;
        set_e(1'b0);
        set_acc(16'hABCD);
        pulse(11'(1) << B_CHAR, 16'hFFFF, 8'h5A);
        m_ac = 16'hAB5A;
        check_state("R5");
    endtask

    task automatic t_inv;
        set_acc(16'hAB5A);
        pulse(11'(1) << B_INV, '0, '0);
        m_ac = 16'h54A5;
        check_state("R6");
    endtask

    task automatic t_rotr;
        set_e(1'b1);
        set_acc(16'h0003);
        pulse(11'(1) << B_ROTR, '0, '0);
        m_ac = 16'h8001; m_e = 1'b1;
        check_state("R7 flag in");
        set_e(1'b0);
        set_acc(16'h0002);
        pulse(11'(1) << B_ROTR, '0, '0);
        m_ac = 16'h0001; m_e = 1'b0;
        check_state("R7 zero out");
    endtask

    task automatic t_rotl;
        set_e(1'b0);
        set_acc(16'hC000);
        pulse(11'(1) << B_ROTL, '0, '0);
        m_ac = 16'h8000; m_e = 1'b1;
        check_state("R8 bit15 out");
        pulse(11'(1) << B_ROTL, '0, '0);
        m_ac = 16'h0001; m_e = 1'b1;
        check_state("R8 flag in");
    endtask

    task automatic t_incr;
        set_e(1'b0);
        set_acc(16'h00FF);
        pulse(11'(1) << B_INCR, '0, '0);
        m_ac = 16'h0100;
        check_state("R9");
        set_acc(16'hFFFF);
        pulse(11'(1) << B_INCR, '0, '0);
        m_ac = 16'h0000;
        check_state("R9 wrap");
    endtask

    task automatic t_zero;
        set_e(1'b1);
        set_acc(16'h8000);
        pulse(11'(1) << B_ZERO, 16'h1111, '0);
        m_ac = '0;
        check_state("R10");
    endtask

    task automatic t_eops;
        set_acc(16'h5555);
        set_e(1'b1);
        pulse(11'(1) << B_ECLR, '0, '0);
        m_e = 1'b0;
        check_state("R11 clear");
        pulse(11'(1) << B_EINV, '0, '0);
        m_e = 1'b1;
        check_state("R11 invert");
    endtask

    task automatic t_idle;
        set_acc(16'h1357);
        set_e(1'b1);
        pulse('0, 16'hFFFF, 8'hFF);
        check_state("R12");
    endtask

    task automatic t_multi;
        set_acc(16'h1357);
        set_e(1'b1);
        pulse((11'(1) << B_AND) | (11'(1) << B_INCR), 16'h0000, '0);
        check_state("R13 and+incr");
        pulse((11'(1) << B_ZERO) | (11'(1) << B_ECLR), '0, '0);
        check_state("R13 zero+eclr");
        pulse(11'h7FF, 16'h0F0F, 8'hAA);
        check_state("R13 all");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_load;
        t_and;
        t_add;
        t_char;
        t_inv;
        t_rotr;
        t_rotl;
        t_incr;
        t_zero;
        t_eops;
        t_idle;
        t_multi;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule